// File: doc/BRIEF.md
# SPI Register Target with In-Band Wait States

This block lets an SPI host reach a single 64-byte scratch register through a small framed protocol. Each transaction starts with a four-byte command header. The first header byte chooses the direction and the payload size, and the other three carry an address that is not used. A flow-control phase follows, in which the target answers with busy bytes until the fabric raises its ready input. A payload of 1 to 64 bytes then goes into or out of the scratch register.

The host side is the four SPI pins, in mode 0 with 8-bit frames sent MSB first. A system clock at least four times the SCK rate oversamples SCK, MOSI and chip select through two-flop synchronizers. The target samples MOSI on SCK rising edges and launches MISO on falling edges. The length decoded from the header is the only thing that ends a transaction, so a host can run transactions back to back inside one chip-select window. Releasing chip select at any point throws the target back to the start of a header.

Top module: `spi_regtarget`

## Requirements
- R1: Frames are 8 bits, sent MSB first in SPI mode 0. Each MISO bit is launched after an SCK falling edge, and the first bit of every response byte is valid before that byte's first SCK rising edge.
- R2: While the four header bytes arrive, the target returns 0xFF, 0xFF, 0xFF and then 0xFE. The cleared LSB of the fourth byte tells the host that a wait phase follows.
- R3: In header byte 0, bit 7 = 1 selects a read and bit 7 = 0 selects a write, and bits 5:0 hold the payload length minus one. Bit 6 of byte 0 and header bytes 1 to 3 have no effect on the transaction.
- R4: In the wait phase, each polled byte returns 0x00 while the target is busy. The target returns 0x01 exactly once, on the first byte that follows a byte boundary at which host_ready was sampled high, and the payload starts on the next byte.
- R5: If host_ready is high at the boundary that ends the fourth header byte, the first wait-phase byte is 0x01.
- R6: MOSI data sent during the header and wait phases never reaches the scratch register.
- R7: On a write of N bytes, the target stores received byte i in scratch byte i for i = 0 to N-1 and returns 0xFF for every payload byte. Scratch bytes at N and above keep their values.
- R8: On a read of N bytes, the target returns scratch bytes 0 to N-1 in order.
- R9: After the last payload byte, the next byte is the first byte of a new header, with no idle byte or chip-select release needed between transactions.
- R10: Releasing chip select aborts the transaction and drops any partly shifted byte. Payload bytes completed before the release stay stored, and the next chip-select assertion starts a new header.
- R11: spi_miso_oe is low whenever spi_cs_n is high and high whenever spi_cs_n is low.
- R12: After reset, every scratch byte reads as 0x00 and spi_miso_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from the host (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| host_ready | input | 1 | Fabric ready flag that ends the wait phase, synchronous to clk |

## Verification
A wrong phase or byte index shows on MISO within a byte or two. A header answer other than FF FF FF FE, a 0x01 that comes one byte too early or too late, or 0xFF where scratch data belongs is visible on the very next frame. A wrong write index or a stray store during the wait phase stays hidden until a later read, where it shows as a wrong byte at a known offset. Long reads after writes of several lengths therefore expose such faults. A missed end of payload breaks the header echo of the next transaction in the same chip-select window, and a missed abort breaks the header echo right after chip select is asserted again.

// File: rtl/spi_rt_pkg.sv
// Shared constants and types for the SPI register target.
// Assumes 8-bit frames; response codes are fixed by the host protocol.
package spi_rt_pkg;

    localparam int BYTE_W = 8;
    localparam int RD_BIT = 7;

    localparam logic [BYTE_W-1:0] RESP_IDLE = 8'hFF;
    localparam logic [BYTE_W-1:0] RESP_FLAG = 8'hFE;
    localparam logic [BYTE_W-1:0] WAIT_BUSY = 8'h00;
    localparam logic [BYTE_W-1:0] WAIT_GO   = 8'h01;

    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_WAIT = 2'd1,
        PH_DATA = 2'd2
    } phase_t;

endpackage

// File: rtl/spi_rt_sync.sv
// Brings SCK, CS and MOSI into the clk domain and finds the SCK edges.
// Assumes clk runs at least 4x SCK and that MOSI is stable around the
// SCK rising edge. STAGES must be at least 2.
module spi_rt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_active,
    output logic mosi_s
);

    logic [STAGES:0]   sck_q;
    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] mosi_q;

    // Synchronizer chains; SCK has one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[STAGES-1:0], sck_i};
            cs_q   <= {cs_q[STAGES-2:0], cs_n_i};
            mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
        end
    end

    assign sck_rise  = sck_q[STAGES-1] & ~sck_q[STAGES];
    assign sck_fall  = ~sck_q[STAGES-1] & sck_q[STAGES];
    assign cs_active = ~cs_q[STAGES-1];
    assign mosi_s    = mosi_q[STAGES-1];

endmodule

// File: rtl/spi_rt_serdes.sv
// Byte shifter for SPI mode 0: captures MOSI on SCK rising edges and
// shifts MISO on falling edges. At the 8th rising edge it reports the
// received byte and loads the next response byte offered by tx_next.
// Assumes the synchronized edge strobes from spi_rt_sync.
module spi_rt_serdes
    import spi_rt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_active,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] tx_next,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso_bit
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-2:0] rx_sh_q;
    logic [BYTE_W-1:0] tx_sh_q;

    // Bit counter, receive shift and transmit shift/load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            tx_sh_q   <= RESP_IDLE;
        end else if (!cs_active) begin
            bit_cnt_q <= '0;
            tx_sh_q   <= RESP_IDLE;
        end else if (sck_rise) begin
            rx_sh_q   <= {rx_sh_q[BYTE_W-3:0], mosi_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST_BIT) begin
                tx_sh_q <= tx_next;
            end
        end else if (sck_fall && bit_cnt_q != '0) begin
            tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b1};
        end
    end

    assign byte_done = cs_active & sck_rise & (bit_cnt_q == LAST_BIT);
    assign rx_byte   = {rx_sh_q, mosi_s};
    assign miso_bit  = tx_sh_q[BYTE_W-1];

endmodule

// File: rtl/spi_rt_ctrl.sv
// Transaction sequencer and scratch storage. Tracks which byte is in
// flight (header, wait or payload), decodes the header, and chooses the
// response byte that follows the current one. host_ready is sampled
// only at byte boundaries. Assumes SCRATCH_BYTES is a power of two
// no larger than 64 and at least HDR_BYTES.
module spi_rt_ctrl
    import spi_rt_pkg::*;
#(
    parameter int SCRATCH_BYTES = 64,
    parameter int HDR_BYTES     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              host_ready,
    output logic [BYTE_W-1:0] tx_next
);

    localparam int IDX_W = $clog2(SCRATCH_BYTES);
    localparam logic [IDX_W-1:0] HDR_LAST_IDX = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] HDR_FLAG_IDX = IDX_W'(HDR_BYTES - 2);

    phase_t            phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  len_m1_q;
    logic              rd_q;
    logic              wait_go_q;
    logic [BYTE_W-1:0] scratch_q [SCRATCH_BYTES];

    logic [IDX_W-1:0]  idx_inc;
    logic [BYTE_W-1:0] wait_code;
    logic              wr_en;

    assign idx_inc   = idx_q + 1'b1;
    assign wait_code = host_ready ? WAIT_GO : WAIT_BUSY;
    assign wr_en     = byte_done && (phase_q == PH_DATA) && !rd_q;

    // Response byte that follows the byte now in flight.
    always_comb begin
        tx_next = RESP_IDLE;
        case (phase_q)
            PH_HDR: begin
                if (idx_q == HDR_LAST_IDX)      tx_next = wait_code;
                else if (idx_q == HDR_FLAG_IDX) tx_next = RESP_FLAG;
                else                            tx_next = RESP_IDLE;
            end
            PH_WAIT: begin
                if (wait_go_q) tx_next = rd_q ? scratch_q[0] : RESP_IDLE;
                else           tx_next = wait_code;
            end
            PH_DATA: begin
                if (idx_q == len_m1_q) tx_next = RESP_IDLE;
                else                   tx_next = rd_q ? scratch_q[idx_inc] : RESP_IDLE;
            end
            default: tx_next = RESP_IDLE;
        endcase
    end

    // Phase and index sequencing, header decode, abort on CS release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_HDR;
            idx_q     <= '0;
            len_m1_q  <= '0;
            rd_q      <= 1'b0;
            wait_go_q <= 1'b0;
        end else if (!cs_active) begin
            phase_q   <= PH_HDR;
            idx_q     <= '0;
            wait_go_q <= 1'b0;
        end else if (byte_done) begin
            case (phase_q)
                PH_HDR: begin
                    if (idx_q == '0) begin
                        rd_q     <= rx_byte[RD_BIT];
                        len_m1_q <= rx_byte[IDX_W-1:0];
                    end
                    if (idx_q == HDR_LAST_IDX) begin
                        phase_q   <= PH_WAIT;
                        idx_q     <= '0;
                        wait_go_q <= host_ready;
                    end else begin
                        idx_q <= idx_inc;
                    end
                end
                PH_WAIT: begin
                    if (wait_go_q) begin
                        phase_q   <= PH_DATA;
                        idx_q     <= '0;
                        wait_go_q <= 1'b0;
                    end else begin
                        wait_go_q <= host_ready;
                    end
                end
                PH_DATA: begin
                    if (idx_q == len_m1_q) begin
                        phase_q <= PH_HDR;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_inc;
                    end
                end
                default: begin
                    phase_q <= PH_HDR;
                    idx_q   <= '0;
                end
            endcase
        end
    end

    // Scratch storage: cleared by reset, written by write payloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SCRATCH_BYTES; i++) begin
                scratch_q[i] <= '0;
            end
        end else if (wr_en) begin
            scratch_q[idx_q] <= rx_byte;
        end
    end

endmodule

// File: rtl/spi_regtarget.sv
// SPI target serving one scratch register through a framed protocol:
// a 4-byte header, a wait phase paced by host_ready, then a 1..64 byte
// payload. Assumes clk is at least 4x SCK and host_ready is synchronous
// to clk. The MISO enable follows the chip-select pin directly.
module spi_regtarget
    import spi_rt_pkg::*;
#(
    parameter int SCRATCH_BYTES = 64,
    parameter int HDR_BYTES     = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe,
    input  logic host_ready
);

    logic              sck_rise;
    logic              sck_fall;
    logic              cs_active;
    logic              mosi_s;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] tx_next;
    logic              miso_bit;

    spi_rt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_i     (spi_sck),
        .cs_n_i    (spi_cs_n),
        .mosi_i    (spi_mosi),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s)
    );

    spi_rt_serdes u_serdes (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s),
        .tx_next   (tx_next),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso_bit  (miso_bit)
    );

    spi_rt_ctrl #(
        .SCRATCH_BYTES (SCRATCH_BYTES),
        .HDR_BYTES     (HDR_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active  (cs_active),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .host_ready (host_ready),
        .tx_next    (tx_next)
    );

    assign spi_miso    = miso_bit;
    assign spi_miso_oe = ~spi_cs_n;

endmodule

// File: rtl/spi_rt_checker.sv
// Protocol checker for the sequencer: phase order, wait-state release,
// end of payload and abort. Bound into every spi_rt_ctrl instance.
module spi_rt_checker
    import spi_rt_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int HDR_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_active,
    input logic              byte_done,
    input logic              host_ready,
    input phase_t            phase,
    input logic [IDX_W-1:0]  idx,
    input logic [IDX_W-1:0]  len_m1,
    input logic              wait_go,
    input logic [BYTE_W-1:0] tx_next
);

    localparam logic [IDX_W-1:0] LAST_H = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] FLAG_H = IDX_W'(HDR_BYTES - 2);

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (phase == PH_HDR && idx == '0));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active && !byte_done) |=> ($stable(phase) && $stable(idx)));

    p_flag_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HDR && idx == FLAG_H) |-> (tx_next == RESP_FLAG));

    p_enter_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_HDR && idx == LAST_H) |=> (phase == PH_WAIT));

    p_ready_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_HDR && idx == LAST_H && host_ready) |=> wait_go);

    p_go_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_WAIT && wait_go) |=> (phase == PH_DATA && idx == '0));

    p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA) |-> (idx <= len_m1));

    p_back_to_hdr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_DATA && idx == len_m1) |=> (phase == PH_HDR && idx == '0));

endmodule

bind spi_rt_ctrl spi_rt_checker #(
    .IDX_W     (IDX_W),
    .HDR_BYTES (HDR_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_active  (cs_active),
    .byte_done  (byte_done),
    .host_ready (host_ready),
    .phase      (phase_q),
    .idx        (idx_q),
    .len_m1     (len_m1_q),
    .wait_go    (wait_go_q),
    .tx_next    (tx_next)
);

// File: tb/spi_regtarget_bench.sv
// Self-checking bench: a vector table of transactions run back to back
// in one chip-select window, then directed reset, tri-state and abort tests.
module spi_regtarget_bench;

    localparam int HALF    = 8;
    localparam int SCR     = 64;
    localparam int NVEC    = 9;
    localparam int WD_CYC  = 150000;

    // [18] read, [17:12] length-1, [11:8] wait bytes, [7:0] data seed
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b0, 6'd7,  4'd0, 8'h11},
        {1'b1, 6'd7,  4'd2, 8'h00},
        {1'b0, 6'd63, 4'd1, 8'h3C},
        {1'b1, 6'd63, 4'd3, 8'h00},
        {1'b0, 6'd0,  4'd0, 8'h77},
        {1'b1, 6'd2,  4'd0, 8'h00},
        {1'b1, 6'd0,  4'd5, 8'h00},
        {1'b0, 6'd5,  4'd4, 8'h9E},
        {1'b1, 6'd9,  4'd1, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;
    logic spi_miso_oe;
    logic host_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [7:0] model [SCR];

    always #2 clk = ~clk;

    spi_regtarget u_spi_regtarget (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck     (spi_sck),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .host_ready  (host_ready)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One mode-0 frame; MISO is sampled just before each rising edge.
    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_open();
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_close();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic send_header(input logic rd, input logic b6, input logic [5:0] lm1,
                               input logic [7:0] addr, input string htag);
        logic [7:0] r;
        logic [7:0] hb [4];
        logic [7:0] he [4];
        hb[0] = {rd, b6, lm1};
        hb[1] = addr;
        hb[2] = addr ^ 8'h3C;
        hb[3] = addr + 8'd1;
        he[0] = 8'hFF; he[1] = 8'hFF; he[2] = 8'hFF; he[3] = 8'hFE;
        for (int h = 0; h < 4; h++) begin
            xbyte(hb[h], r);
            chk(htag, r, he[h]);
        end
    endtask

    // Full transaction with wait-phase pacing and payload checks.
    task automatic run_txn(input logic rd, input logic [5:0] lm1, input int dly,
                           input logic [7:0] seed, input string htag, input string rtag);
        logic [7:0] r;
        logic [7:0] d;
        int zeros;
        bit go;
        host_ready = (dly == 0);
        send_header(rd, seed[0], lm1, seed ^ 8'hA7, htag);
        zeros = 0;
        go = 1'b0;
        for (int p = 0; p < 20 && !go; p++) begin
            if (dly != 0 && zeros == dly - 1) host_ready = 1'b1;
            xbyte(8'h5A ^ 8'(p), r);
            if (r == 8'h01) go = 1'b1;
            else if (r == 8'h00) zeros++;
            else chk("R4 wait code", r, 8'h00);
        end
        host_ready = 1'b0;
        chk((dly == 0) ? "R5 zero wait bytes" : "R4 wait byte count", 8'(zeros), 8'(dly));
        chk("R4 release seen", {7'd0, go}, 8'h01);
        for (int i = 0; i <= int'(lm1); i++) begin
            if (rd) begin
                xbyte(8'hC3, r);
                chk(rtag, r, model[i]);
            end else begin
                d = seed + 8'(i * 37);
                xbyte(d, r);
                chk("R7 write echo", r, 8'hFF);
                model[i] = d;
            end
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        for (int i = 0; i < SCR; i++) model[i] = 8'h00;

        // R12, R11: reset state and tri-state control
        repeat (5) @(negedge clk);
        chk("R12 oe in reset", {7'd0, spi_miso_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 oe idle", {7'd0, spi_miso_oe}, 8'h00);
        cs_open();
        chk("R11 oe selected", {7'd0, spi_miso_oe}, 8'h01);
        run_txn(1'b1, 6'd15, 0, 8'h00, "R2", "R12 scratch cleared");
        cs_close();
        chk("R11 oe released", {7'd0, spi_miso_oe}, 8'h00);

        // Vector table: back-to-back transactions in one CS window (R9)
        cs_open();
        for (int v = 0; v < NVEC; v++) begin
            run_txn(VEC[v][18], VEC[v][17:12], int'(VEC[v][11:8]), VEC[v][7:0],
                    "R2 R9 header echo", "R1 R3 R6 R8 read data");
        end
        cs_close();

        // R10: abort in the middle of the header
        cs_open();
        xbyte(8'h83, r);
        chk("R10 partial header", r, 8'hFF);
        xbyte(8'h00, r);
        cs_close();
        cs_open();
        run_txn(1'b1, 6'd3, 1, 8'h00, "R10 header after abort", "R10 read after abort");
        cs_close();

        // R10: abort in the middle of a write payload
        cs_open();
        host_ready = 1'b1;
        send_header(1'b0, 1'b0, 6'd3, 8'h10, "R2");
        xbyte(8'h00, r);
        chk("R5 immediate release", r, 8'h01);
        host_ready = 1'b0;
        xbyte(8'hC1, r);
        model[0] = 8'hC1;
        xbyte(8'hC2, r);
        model[1] = 8'hC2;
        for (int b = 0; b < 3; b++) begin
            spi_mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
        cs_close();
        cs_open();
        run_txn(1'b1, 6'd3, 0, 8'h00, "R10 header after payload abort", "R10 kept bytes");
        cs_close();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule